// File: doc/BRIEF.md
# Retention-Binned DRAM Row Refresh Scheduler

This block is the refresh engine of a memory controller. Instead of refreshing every DRAM row at the worst-case rate, it gives each row a refresh rate that matches how long that row holds its data. Two small membership filters record the rows known to leak quickly. The fast filter holds rows that need a refresh in every base period. The mid filter holds rows that need one in every second period. Every row found in neither filter is treated as strong and is refreshed once every fourth period. One base period corresponds to the conventional 64 ms refresh window.

A row walker moves through all rows in ascending order. It spends `SLOT_CYCLES` clock cycles on each row. When the last row is done, the walker wraps to row 0 and a 2-bit period counter advances. At the end of each row slot, the block asks both filters whether the current row is a member. It then decides from the period counter whether that row is due. A due row produces a one-cycle refresh command that carries the row address and the bin that was used. A row that is not due produces nothing.

Rows are added to a filter through a configuration port. This can happen at start-up or at any later time. A clear input empties both filters. A filter can report a row as a member when it was never inserted. That error only makes the row refresh more often than it needs to. An inserted row is never reported as absent.

Top module: `retention_refresh_sched`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `ref_valid` is 0. The first slot after reset covers row 0 in period 0.
- R2: A slot lasts `SLOT_CYCLES` cycles. `ref_valid` is high only in the cycle that directly follows the last cycle of a slot. It is never high in two consecutive cycles.
- R3: Slots visit rows 0, 1, …, 2^ROW_W−1 in order and then wrap to 0. Each wrap advances the period counter modulo 4. `ref_row` carries the address of the row whose slot just ended.
- R4: A row that is in neither filter is commanded only when its slot ends in period 0.
- R5: A row that is in the mid filter but not in the fast filter is commanded only when its slot ends in period 0 or period 2.
- R6: A row that is in the fast filter is commanded at the end of every one of its slots.
- R7: A row that is present in both filters is handled as a fast row and reported with bin code 0.
- R8: Each filter is `FILT_BITS` bits wide and uses `N_HASH` hash positions. The bit index for salt s is (row·(2s+1) + 11·s) mod FILT_BITS. The fast filter uses salts 0 to N_HASH−1 and the mid filter uses salts N_HASH to 2·N_HASH−1. A row is a member of a filter when all of its bits in that filter are set. An inserted row therefore never tests absent.
- R9: An insert that is sampled on a clock edge is seen by every slot that ends on a later edge. This holds for inserts made during operation.
- R10: `cfg_clear` empties both filters. An insert that arrives in the same cycle as the clear is kept.
- R11: `ref_bin` encodes the bin that was used: 0 for fast, 1 for mid, 2 for slow. Code 3 never appears with `ref_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ins_valid | input | 1 | Insert `cfg_ins_row` into a filter this cycle |
| cfg_ins_fast | input | 1 | Selects the filter for the insert: 1 for the fast filter, 0 for the mid filter |
| cfg_ins_row | input | ROW_W | Row address to insert |
| cfg_clear | input | 1 | Empty both filters |
| ref_valid | output | 1 | Refresh command strobe |
| ref_row | output | ROW_W | Row address to refresh |
| ref_bin | output | 2 | Bin used for the command (0 fast, 1 mid, 2 slow) |

## Verification
Every internal state of this block becomes visible at the ports within one walk of the rows. If the walker drifts, `ref_row` is out of sequence at the next command. If the period counter is wrong, a slow or mid row fires in the wrong period, or fails to fire, in the first lap where that row is visited. A lost or stray filter bit shows up as a count of refreshes per row over four periods that differs from the count set by the row's membership. A bench model that knows the hash rule can predict every cycle exactly. The output is therefore compared on every clock, in addition to the window counts for each row.

// File: rtl/rr_pkg.sv
package rr_pkg;

    typedef enum logic [1:0] {
        BIN_FAST = 2'd0,
        BIN_MID  = 2'd1,
        BIN_SLOW = 2'd2
    } bin_e;

    localparam int PERIOD_W = 2;

    // Fast membership wins over mid; everything else is slow.
    function automatic bin_e pick_bin(input logic hit_fast, input logic hit_mid);
        if (hit_fast)     return BIN_FAST;
        else if (hit_mid) return BIN_MID;
        else              return BIN_SLOW;
    endfunction

    // Period rule per bin: fast every lap, mid on even laps, slow on lap 0.
    function automatic logic row_due(input bin_e b, input logic [PERIOD_W-1:0] period);
        case (b)
            BIN_FAST: return 1'b1;
            BIN_MID:  return (period[0] == 1'b0);
            BIN_SLOW: return (period == '0);
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rr_bloom.sv
module rr_bloom #(
    parameter int ROW_W     = 6,
    parameter int FILT_BITS = 32,
    parameter int N_HASH    = 2,
    parameter int SALT_BASE = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             ins,
    input  logic [ROW_W-1:0] ins_row,
    input  logic [ROW_W-1:0] q_row,
    output logic             hit
);
    localparam int IDX_W = $clog2(FILT_BITS);

    function automatic logic [IDX_W-1:0] hidx(input logic [ROW_W-1:0] r, input int s);
        int t;
        t = int'(r) * (2 * s + 1) + 11 * s;
        return t[IDX_W-1:0];
    endfunction

    logic [FILT_BITS-1:0] bits_q;
    logic [FILT_BITS-1:0] ins_mask;
    logic [N_HASH-1:0]    q_set;

    genvar k;
    generate
        for (k = 0; k < N_HASH; k++) begin : g_hash
            logic [IDX_W-1:0] q_idx;
            assign q_idx    = hidx(q_row, SALT_BASE + k);
            assign q_set[k] = bits_q[q_idx];
        end
    endgenerate

    always_comb begin
        ins_mask = '0;
        for (int j = 0; j < N_HASH; j++) begin
            ins_mask[hidx(ins_row, SALT_BASE + j)] = 1'b1;
        end
    end

    assign hit = &q_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else if (clear) begin
            bits_q <= ins ? ins_mask : '0;
        end else if (ins) begin
            bits_q <= bits_q | ins_mask;
        end
    end

endmodule

// File: rtl/rr_walker.sv
module rr_walker #(
    parameter int ROW_W       = 6,
    parameter int SLOT_CYCLES = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    output logic [ROW_W-1:0]            row,
    output logic [rr_pkg::PERIOD_W-1:0] period,
    output logic                        fire
);
    localparam int SLOT_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOT_CYCLES - 1);
    localparam logic [ROW_W-1:0]  ROW_LAST  = '1;

    logic [SLOT_W-1:0] slot_q;

    assign fire = (slot_q == SLOT_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
            row    <= '0;
            period <= '0;
        end else if (fire) begin
            slot_q <= '0;
            row    <= row + 1'b1;
            if (row == ROW_LAST) begin
                period <= period + 1'b1;
            end
        end else begin
            slot_q <= slot_q + 1'b1;
        end
    end

endmodule

// File: rtl/retention_refresh_sched.sv
module retention_refresh_sched #(
    parameter int ROW_W       = 6,
    parameter int FILT_BITS   = 32,
    parameter int N_HASH      = 2,
    parameter int SLOT_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_ins_valid,
    input  logic             cfg_ins_fast,
    input  logic [ROW_W-1:0] cfg_ins_row,
    input  logic             cfg_clear,
    output logic             ref_valid,
    output logic [ROW_W-1:0] ref_row,
    output logic [1:0]       ref_bin
);
    import rr_pkg::*;

    localparam int N_FILT = 2;

    logic [ROW_W-1:0]    row;
    logic [PERIOD_W-1:0] period;
    logic                slot_fire;
    logic [N_FILT-1:0]   hit;
    bin_e                cur_bin;
    logic                due;

    rr_walker #(
        .ROW_W       (ROW_W),
        .SLOT_CYCLES (SLOT_CYCLES)
    ) walker_i (
        .clk    (clk),
        .rst    (rst),
        .row    (row),
        .period (period),
        .fire   (slot_fire)
    );

    genvar f;
    generate
        for (f = 0; f < N_FILT; f++) begin : g_filt
            logic ins_here;
            assign ins_here = cfg_ins_valid & ((f == 0) ? cfg_ins_fast : ~cfg_ins_fast);
            rr_bloom #(
                .ROW_W     (ROW_W),
                .FILT_BITS (FILT_BITS),
                .N_HASH    (N_HASH),
                .SALT_BASE (f * N_HASH)
            ) bloom_i (
                .clk     (clk),
                .rst     (rst),
                .clear   (cfg_clear),
                .ins     (ins_here),
                .ins_row (cfg_ins_row),
                .q_row   (row),
                .hit     (hit[f])
            );
        end
    endgenerate

    always_comb begin
        cur_bin = pick_bin(hit[0], hit[1]);
        due     = row_due(cur_bin, period);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_valid <= 1'b0;
            ref_row   <= '0;
            ref_bin   <= 2'd0;
        end else begin
            ref_valid <= slot_fire & due;
            if (slot_fire) begin
                ref_row <= row;
                ref_bin <= cur_bin;
            end
        end
    end

endmodule

// File: rtl/rr_sched_chk.sv
module rr_sched_chk #(
    parameter int ROW_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             fire,
    input logic [ROW_W-1:0] row,
    input logic [1:0]       period,
    input logic             hit_a,
    input logic             hit_b,
    input logic             ref_valid,
    input logic [1:0]       ref_bin
);
    // R2
    cmd_after_slot_chk: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> $past(fire));

    // R2
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
        ref_valid |=> !ref_valid);

    // R3
    row_step_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (row == ROW_W'($past(row) + 1'b1)));

    // R4
    slow_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !hit_a && !hit_b && period != 2'd0) |=> !ref_valid);

    // R5
    mid_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !hit_a && hit_b && period[0]) |=> !ref_valid);

    // R6
    fast_every_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && hit_a) |=> ref_valid);

    // R7
    fast_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && hit_a && hit_b) |=> (ref_bin == 2'd0));

    // R11
    bin_code_chk: assert property (@(posedge clk) disable iff (rst)
        ref_valid |-> (ref_bin != 2'd3));

endmodule

bind retention_refresh_sched rr_sched_chk #(
    .ROW_W (ROW_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .fire      (slot_fire),
    .row       (row),
    .period    (period),
    .hit_a     (hit[0]),
    .hit_b     (hit[1]),
    .ref_valid (ref_valid),
    .ref_bin   (ref_bin)
);

// File: tb/retention_refresh_sched_tb.sv
module retention_refresh_sched_tb_top;
    localparam int ROW_W = 6;
    localparam int FB    = 32;
    localparam int NH    = 2;
    localparam int S     = 4;
    localparam int ROWS  = 1 << ROW_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_ins_valid = 1'b0;
    logic             cfg_ins_fast = 1'b0;
    logic [ROW_W-1:0] cfg_ins_row = '0;
    logic             cfg_clear = 1'b0;
    logic             ref_valid;
    logic [ROW_W-1:0] ref_row;
    logic [1:0]       ref_bin;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    retention_refresh_sched #(
        .ROW_W (ROW_W), .FILT_BITS (FB), .N_HASH (NH), .SLOT_CYCLES (S)
    ) dut_i (
        .clk (clk), .rst (rst),
        .cfg_ins_valid (cfg_ins_valid), .cfg_ins_fast (cfg_ins_fast),
        .cfg_ins_row (cfg_ins_row), .cfg_clear (cfg_clear),
        .ref_valid (ref_valid), .ref_row (ref_row), .ref_bin (ref_bin)
    );

    // Behavioural reference state
    bit fa [FB];
    bit fm [FB];
    int m_slot, m_row, m_per;
    bit exp_valid;
    int exp_row, exp_bin;

    function automatic int hsh(input int r, input int s);
        return (r * (2 * s + 1) + 11 * s) % FB;
    endfunction

    function automatic bit in_fast(input int r);
        bit ok = 1;
        for (int k = 0; k < NH; k++) if (!fa[hsh(r, k)]) ok = 0;
        return ok;
    endfunction

    function automatic bit in_mid(input int r);
        bit ok = 1;
        for (int k = 0; k < NH; k++) if (!fm[hsh(r, NH + k)]) ok = 0;
        return ok;
    endfunction

    function automatic int exp_cnt(input int r);
        if (in_fast(r)) return 4;
        if (in_mid(r))  return 2;
        return 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_slot = 0; m_row = 0; m_per = 0;
            exp_valid = 0; exp_row = 0; exp_bin = 0;
            for (int i = 0; i < FB; i++) begin fa[i] = 0; fm[i] = 0; end
        end else begin
            if (m_slot == S - 1) begin
                int b;
                b = in_fast(m_row) ? 0 : (in_mid(m_row) ? 1 : 2);
                exp_valid = (b == 0) || (b == 1 && (m_per % 2) == 0) || (b == 2 && m_per == 0);
                exp_row = m_row;
                exp_bin = b;
                m_slot = 0;
                if (m_row == ROWS - 1) begin
                    m_row = 0;
                    m_per = (m_per + 1) % 4;
                end else begin
                    m_row = m_row + 1;
                end
            end else begin
                exp_valid = 0;
                m_slot = m_slot + 1;
            end
            if (cfg_clear) for (int i = 0; i < FB; i++) begin fa[i] = 0; fm[i] = 0; end
            if (cfg_ins_valid) begin
                for (int k = 0; k < NH; k++) begin
                    if (cfg_ins_fast) fa[hsh(int'(cfg_ins_row), k)] = 1;
                    else              fm[hsh(int'(cfg_ins_row), NH + k)] = 1;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Per-cycle comparison and observation counters
    int cnt [ROWS];
    int last_bin [ROWS];
    int b2b = 0;
    bit prev_v = 0;

    always @(negedge clk) begin
        if (!rst) begin
            string tg;
            tg = (exp_bin == 0) ? "R6 strobe" : ((exp_bin == 1) ? "R5 strobe" : "R4 strobe");
            chk(ref_valid == exp_valid, tg, int'(ref_valid), int'(exp_valid));
            if (ref_valid && exp_valid) begin
                chk(int'(ref_row) == exp_row, "R3 row", int'(ref_row), exp_row);
                chk(int'(ref_bin) == exp_bin, "R11 bin", int'(ref_bin), exp_bin);
            end
            if (ref_valid) begin
                cnt[ref_row]++;
                last_bin[ref_row] = int'(ref_bin);
                if (prev_v) b2b++;
            end
            prev_v = ref_valid;
        end
    end

    task automatic insert(input bit fast, input int r, input bit clr);
        @(negedge clk);
        cfg_ins_valid = 1; cfg_ins_fast = fast; cfg_ins_row = ROW_W'(r); cfg_clear = clr;
        @(negedge clk);
        cfg_ins_valid = 0; cfg_clear = 0;
    endtask

    // Count commands over exactly four periods, starting at a lap boundary.
    task automatic window();
        do @(negedge clk); while (!(m_row == 0 && m_slot == 0));
        #1;
        for (int i = 0; i < ROWS; i++) cnt[i] = 0;
        repeat (4 * ROWS * S) @(negedge clk);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int rs;
        repeat (4) @(negedge clk);
        chk(ref_valid == 0, "R1 reset strobe", int'(ref_valid), 0);
        rst = 0;
        @(negedge clk);
        chk(ref_valid == 0, "R1 after reset", int'(ref_valid), 0);

        insert(1, 5, 0);
        insert(0, 12, 0);
        insert(1, 40, 0);
        insert(0, 40, 0);
        insert(0, 33, 0);
        window();
        chk(cnt[5] == 4, "R6 fast row count", cnt[5], 4);
        chk(cnt[12] == exp_cnt(12) && cnt[12] >= 2, "R5 mid row count", cnt[12], exp_cnt(12));
        chk(cnt[40] == 4 && last_bin[40] == 0, "R7 both-bin row", cnt[40] * 10 + last_bin[40], 40);
        chk(cnt[33] >= 2 && in_mid(33), "R8 no false negative", cnt[33], 2);
        rs = -1;
        for (int i = 0; i < ROWS; i++) if (rs < 0 && exp_cnt(i) == 1) rs = i;
        chk(rs >= 0 && cnt[rs] == 1, "R4 slow row count", (rs >= 0) ? cnt[rs] : -1, 1);
        begin
            int miss = 0;
            for (int i = 0; i < ROWS; i++) if (cnt[i] < 1) miss++;
            chk(miss == 0, "R3 every row visited", miss, 0);
        end

        // Runtime insert of a slow row into the fast filter
        repeat (37) @(negedge clk);
        insert(1, rs, 0);
        window();
        chk(cnt[rs] == 4, "R9 runtime insert", cnt[rs], 4);

        // Clear with a same-cycle insert into the mid filter
        insert(0, 7, 1);
        window();
        chk(!in_fast(5) && cnt[5] == exp_cnt(5), "R10 cleared fast row", cnt[5], exp_cnt(5));
        chk(cnt[7] == 2, "R10 same-cycle insert kept", cnt[7], 2);
        chk(b2b == 0, "R2 no back-to-back strobes", b2b, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule